// File: doc/BRIEF.md
# Power Mode Controller

This block holds the power mode of a small system-on-chip: Operating, Idle or Standby. Mode-change strobes from the register file, the interrupt controller and the supply monitors drive it. All event inputs arrive already deglitched. In Operating every clock runs. Idle stops only the CPU clock. Standby leaves only the real-time clock domain alive.

The only way out of Standby is back to Operating. A qualified wake request starts that exit. The request can come from a rising edge on the wake pin, or from an interrupt when the keyboard wake path is enabled. Both sources are honoured only while the separate power-good qualifier is high. The controller raises a wake request to the wake sequencer and holds it. It enters Operating only when the sequencer returns a run acknowledge.

A low battery seen outside Standby does not change the mode. It sets a sticky interrupt flag, and software clears that flag with a strobe.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `pwrState` is one-hot, with bit 0 for Operating, bit 1 for Idle and bit 2 for Standby. Out of reset the block is in Standby with `cpuClkEn`, `wakeReq` and `lowBatIrq` all low.
- R2: `cpuClkEn` is high exactly while the state is Operating.
- R3: In Operating, `haltWr` moves the block to Idle at the next edge. In Idle, `irqPending` moves it back to Operating at the next edge.
- R4: In Operating, any one of `standbyWr`, `userRst` or `pwrFail` moves the block to Standby, and takes priority over `haltWr`. In Idle, `userRst` or `pwrFail` moves it to Standby.
- R5: `porEvt` moves the block from any state to Standby at the next edge and drops any pending wake request.
- R6: In Standby, a wake rising edge raises `wakeReq` at that edge. A rising edge means `wakeIn` sampled low and then high at consecutive edges. It counts only while `powerGood` is high and `wakeDis` is low. Outside Standby, `wakeIn` has no effect.
- R7: A wake edge that occurs while `powerGood` is low is discarded. Before a new edge can count, `wakeIn` must be sampled low while `powerGood` is high.
- R8: While `wakeDis` is high, no wake pin activity raises `wakeReq`.
- R9: In Standby with `powerGood` high, `irqPending` raises `wakeReq` when `kbdWakeEn` is high. After `porEvt`, `userRst` or `pwrFail`, this interrupt wake path stays blocked until `kbdWakeEn` is sampled low and then high. Reset leaves the path blocked.
- R10: `wakeReq` stays high until `runAck`. With `wakeReq` high, `runAck` moves Standby to Operating at the next edge and clears `wakeReq`. Standby never leaves except to Operating.
- R11: `lowBat` outside Standby sets `lowBatIrq`, which holds until `lowBatClr`, and the state is unchanged. In Standby, `lowBat` does not set the flag.
- R12: In Standby, `pwrFail` is ignored. The state stays in Standby and the interrupt wake path stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| haltWr | input | 1 | Write strobe to the halt location |
| standbyWr | input | 1 | Write strobe to the standby location |
| irqPending | input | 1 | Interrupt pending |
| kbdWakeEn | input | 1 | Keyboard/interrupt wake enable bit |
| wakeIn | input | 1 | Deglitched wake pin |
| wakeDis | input | 1 | Wake pin disable bit |
| lowBat | input | 1 | Deglitched low-battery condition |
| lowBatClr | input | 1 | Software clear of the low-battery flag |
| userRst | input | 1 | Deglitched user reset event |
| pwrFail | input | 1 | Deglitched power-fail event |
| porEvt | input | 1 | Power-on reset event |
| powerGood | input | 1 | Qualified power-good |
| runAck | input | 1 | Run acknowledge from wake sequencer |
| pwrState | output | 3 | One-hot power state |
| cpuClkEn | output | 1 | CPU clock enable |
| wakeReq | output | 1 | Wake request to the sequencer |
| lowBatIrq | output | 1 | Sticky low-battery interrupt flag |

## Verification
The assertions assume that every event input is a single-cycle deglitched level already synchronous to `clk`. They also assume that `runAck` carries meaning only while a wake request is pending. The stimulus changes inputs only between edges and pulses each reset or strobe for one cycle. It keeps `powerGood` steady across each wake edge, so each edge falls unambiguously inside or outside qualification. `runAck` is asserted only after `wakeReq` has been observed high.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PM_OPER = 3'b001,
    PM_IDLE = 3'b010,
    PM_STBY = 3'b100
  } pmState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic inStandby;
    logic reqSet;
    logic reqClr;
    logic kbdBlock;
  } pmStrobe_t;
endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      haltWr,
  input  logic      standbyWr,
  input  logic      irqPending,
  input  logic      userRst,
  input  logic      pwrFail,
  input  logic      porEvt,
  input  logic      runAck,
  input  logic      wakeTrig,
  input  logic      wakeReq,
  output pmState_t  state,
  output pmStrobe_t strb
);
  pmState_t nextState;
  logic inStby;

  assign inStby = (state == PM_STBY);

  always_comb begin
    nextState = state;
    if (porEvt) begin
      nextState = PM_STBY;
    end else begin
      case (state)
        PM_OPER: begin
          if (standbyWr || userRst || pwrFail) nextState = PM_STBY;
          else if (haltWr)                     nextState = PM_IDLE;
        end
        PM_IDLE: begin
          if (userRst || pwrFail) nextState = PM_STBY;
          else if (irqPending)    nextState = PM_OPER;
        end
        PM_STBY: begin
          if (wakeReq && runAck) nextState = PM_OPER;
        end
        default: nextState = PM_STBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PM_STBY;
    else       state <= nextState;
  end

  always_comb begin
    strb.inStandby = inStby;
    strb.reqSet    = inStby && wakeTrig && !porEvt;
    strb.reqClr    = porEvt || (inStby && wakeReq && runAck);
    strb.kbdBlock  = porEvt || userRst || (pwrFail && !inStby);
  end

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(state)); // R1
  AST_STBY_ONLY_TO_OPER: assert property (@(posedge clk) disable iff (!rstN)
    (state == PM_STBY) |=> (state == PM_STBY || state == PM_OPER)); // R10
  AST_NO_EXIT_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (state == PM_STBY && !runAck) |=> (state == PM_STBY)); // R10
  AST_POR_TO_STBY: assert property (@(posedge clk) disable iff (!rstN)
    porEvt |=> (state == PM_STBY)); // R5
  AST_HALT_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == PM_OPER && haltWr && !standbyWr && !userRst && !pwrFail && !porEvt)
    |=> (state == PM_IDLE)); // R3
endmodule

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  pmStrobe_t strb,
  input  logic      wakeIn,
  input  logic      wakeDis,
  input  logic      powerGood,
  input  logic      irqPending,
  input  logic      kbdWakeEn,
  input  logic      lowBat,
  input  logic      lowBatClr,
  output logic      wakeTrig,
  output logic      wakeReq,
  output logic      lowBatIrq
);
  logic wakePrev, wakeArmed, kbdPrev, kbdBlocked;
  logic wakeRise, kbdRise, pinWake, irqWake;

  assign wakeRise = wakeIn && !wakePrev;
  assign kbdRise  = kbdWakeEn && !kbdPrev;
  assign pinWake  = wakeRise && wakeArmed && !wakeDis;
  assign irqWake  = irqPending && kbdWakeEn && !kbdBlocked;
  assign wakeTrig = strb.inStandby && !wakeReq && powerGood && (pinWake || irqWake);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakePrev   <= 1'b0;
      wakeArmed  <= 1'b0;
      kbdPrev    <= 1'b1;
      kbdBlocked <= 1'b1;
      wakeReq    <= 1'b0;
      lowBatIrq  <= 1'b0;
    end else begin
      wakePrev <= wakeIn;
      kbdPrev  <= kbdWakeEn;
      if (!powerGood)  wakeArmed <= 1'b0;
      else if (!wakeIn) wakeArmed <= 1'b1;
      if (strb.kbdBlock)  kbdBlocked <= 1'b1;
      else if (kbdRise)   kbdBlocked <= 1'b0;
      if (strb.reqClr)      wakeReq <= 1'b0;
      else if (strb.reqSet) wakeReq <= 1'b1;
      if (lowBat && !strb.inStandby) lowBatIrq <= 1'b1;
      else if (lowBatClr)             lowBatIrq <= 1'b0;
    end
  end

  AST_REQ_ONLY_IN_STBY: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> strb.inStandby); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && !runAckSeen() ) |=> wakeReq); // R10
  AST_DIS_BLOCKS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (wakeDis && !irqPending && !wakeReq) |=> !wakeReq); // R8
  AST_LOWBAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (lowBatIrq && !lowBatClr) |=> lowBatIrq); // R11
  AST_NO_QUAL_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (!powerGood && !wakeReq) |=> !wakeReq); // R7

  function automatic logic runAckSeen();
    return strb.reqClr;
  endfunction
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               haltWr,
  input  logic               standbyWr,
  input  logic               irqPending,
  input  logic               kbdWakeEn,
  input  logic               wakeIn,
  input  logic               wakeDis,
  input  logic               lowBat,
  input  logic               lowBatClr,
  input  logic               userRst,
  input  logic               pwrFail,
  input  logic               porEvt,
  input  logic               powerGood,
  input  logic               runAck,
  output logic [STATE_W-1:0] pwrState,
  output logic               cpuClkEn,
  output logic               wakeReq,
  output logic               lowBatIrq
);
  pmState_t  state;
  pmStrobe_t strb;
  logic      wakeTrig;

  pwr_mode_fsm u_fsm (
    .clk(clk), .rstN(rstN), .haltWr(haltWr), .standbyWr(standbyWr),
    .irqPending(irqPending), .userRst(userRst), .pwrFail(pwrFail),
    .porEvt(porEvt), .runAck(runAck), .wakeTrig(wakeTrig),
    .wakeReq(wakeReq), .state(state), .strb(strb)
  );

  pwr_mode_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wakeIn(wakeIn), .wakeDis(wakeDis),
    .powerGood(powerGood), .irqPending(irqPending), .kbdWakeEn(kbdWakeEn),
    .lowBat(lowBat), .lowBatClr(lowBatClr), .wakeTrig(wakeTrig),
    .wakeReq(wakeReq), .lowBatIrq(lowBatIrq)
  );

  assign pwrState = state;
  assign cpuClkEn = (state == PM_OPER);

  AST_LOWBAT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (lowBat && !porEvt && !userRst && !pwrFail && !standbyWr && !haltWr
     && !irqPending && !runAck) |=> $stable(pwrState)); // R11
  AST_CLK_OFF_IN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'b010) |-> !cpuClkEn); // R2
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltWr = 0, standbyWr = 0, irqPending = 0, kbdWakeEn = 0, wakeIn = 0;
  logic wakeDis = 0, lowBat = 0, lowBatClr = 0, userRst = 0, pwrFail = 0;
  logic porEvt = 0, powerGood = 0, runAck = 0;
  logic [2:0] pwrState;
  logic cpuClkEn, wakeReq, lowBatIrq;

  int nChecks = 0;
  int nFails = 0;

  typedef struct {
    logic [2:0] st;
    logic       ce;
    logic       rq;
    logic       lb;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  localparam logic [2:0] OP = 3'b001, ID = 3'b010, SB = 3'b100;

  always #4 clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rstN(rstN), .haltWr(haltWr), .standbyWr(standbyWr),
    .irqPending(irqPending), .kbdWakeEn(kbdWakeEn), .wakeIn(wakeIn),
    .wakeDis(wakeDis), .lowBat(lowBat), .lowBatClr(lowBatClr),
    .userRst(userRst), .pwrFail(pwrFail), .porEvt(porEvt),
    .powerGood(powerGood), .runAck(runAck), .pwrState(pwrState),
    .cpuClkEn(cpuClkEn), .wakeReq(wakeReq), .lowBatIrq(lowBatIrq)
  );

  task automatic compare(input expItem_t e);
    nChecks++;
    if (pwrState !== e.st || cpuClkEn !== e.ce || wakeReq !== e.rq || lowBatIrq !== e.lb) begin
      nFails++;
      $display("FAIL %s: got st=%b ce=%b rq=%b lb=%b exp st=%b ce=%b rq=%b lb=%b",
               e.tag, pwrState, cpuClkEn, wakeReq, lowBatIrq, e.st, e.ce, e.rq, e.lb);
    end
  endtask

  // monitor: pops one expectation per edge, shortly after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  // driver: inputs already set by caller; push expectation, pass one edge
  task automatic tick(input string tag, input logic [2:0] st, input logic rq, input logic lb);
    expItem_t e;
    e.st = st; e.ce = (st == OP); e.rq = rq; e.lb = lb; e.tag = tag;
    expQ.push_back(e);
    @(posedge clk);
    #2;
    haltWr = 0; standbyWr = 0; userRst = 0; pwrFail = 0; porEvt = 0; lowBatClr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    begin
      expItem_t r;
      r.st = SB; r.ce = 0; r.rq = 0; r.lb = 0; r.tag = "R1 reset state";
      compare(r);
    end
    rstN = 1;
    @(posedge clk); #2;

    wakeIn = 1;                 tick("R7 edge before power-good", SB, 0, 0);
    powerGood = 1;              tick("R7 qualify while high", SB, 0, 0);
    wakeIn = 0;                 tick("R7 arm on low", SB, 0, 0);
    wakeIn = 1;                 tick("R6 wake rise", SB, 1, 0);
                                tick("R10 request held", SB, 1, 0);
    runAck = 1;                 tick("R10 ack to operating", OP, 0, 0);
    runAck = 0; wakeIn = 0; kbdWakeEn = 1; tick("R2 operating", OP, 0, 0);
    wakeIn = 1;                 tick("R6 wake ignored outside standby", OP, 0, 0);
    lowBat = 1;                 tick("R11 lowbat sets flag", OP, 0, 1);
    lowBat = 0;                 tick("R11 flag sticky", OP, 0, 1);
    lowBatClr = 1;              tick("R11 clear", OP, 0, 0);
    haltWr = 1;                 tick("R3 halt to idle", ID, 0, 0);
    irqPending = 1;             tick("R3 irq to operating", OP, 0, 0);
    irqPending = 0; haltWr = 1; userRst = 1; wakeIn = 0;
                                tick("R4 user reset beats halt", SB, 0, 0);
    irqPending = 1;             tick("R9 kbd wake blocked", SB, 0, 0);
    irqPending = 0; kbdWakeEn = 0; tick("R9 enable low", SB, 0, 0);
    kbdWakeEn = 1;              tick("R9 enable rewritten", SB, 0, 0);
    irqPending = 1;             tick("R9 irq wake", SB, 1, 0);
    irqPending = 0; runAck = 1; tick("R10 ack", OP, 0, 0);
    runAck = 0; standbyWr = 1;  tick("R4 standby write", SB, 0, 0);
    pwrFail = 1;                tick("R12 power fail in standby", SB, 0, 0);
    irqPending = 1;             tick("R12 kbd path still open", SB, 1, 0);
    irqPending = 0; runAck = 1; tick("R10 ack", OP, 0, 0);
    runAck = 0; wakeDis = 1; standbyWr = 1; tick("R4 standby write", SB, 0, 0);
    lowBat = 1;                 tick("R11 lowbat in standby", SB, 0, 0);
    lowBat = 0; wakeIn = 1;     tick("R8 disabled wake", SB, 0, 0);
    wakeDis = 0; wakeIn = 0;    tick("R8 wake low", SB, 0, 0);
    wakeIn = 1;                 tick("R6 enabled wake", SB, 1, 0);
    porEvt = 1;                 tick("R5 por drops request", SB, 0, 0);
    wakeIn = 0;                 tick("R5 wake low", SB, 0, 0);
    wakeIn = 1;                 tick("R6 wake rise", SB, 1, 0);
    runAck = 1;                 tick("R10 ack", OP, 0, 0);
    runAck = 0; pwrFail = 1;    tick("R4 power fail in operating", SB, 0, 0);
    wakeIn = 0;                 tick("R6 wake low", SB, 0, 0);
    wakeIn = 1;                 tick("R6 wake rise", SB, 1, 0);
    runAck = 1;                 tick("R10 ack", OP, 0, 0);
    runAck = 0; porEvt = 1;     tick("R5 por from operating", SB, 0, 0);
    @(posedge clk); #2;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule